// File: doc/BRIEF.md
# Sleep and Startup Controller

This block sets the clock and power state of a small microcontroller core. Software running on the core asks for sleep with a one-cycle request and a two-bit mode code. The light sleep (idle) stops only the CPU clock. Memory, timer, serial port and interrupt logic keep their clock. The deep sleep (power-down) stops the oscillator and every clock enable, and the register contents are held. An interrupt ends idle at once. An interrupt or a reset ends power-down.

Every reset and every exit from power-down passes through a startup phase. In that phase the oscillator runs but the core is held. A counter of reference ticks holds the core until the oscillator has had time to settle. The oscillator itself is outside this block and is modelled by the `ref_tick` input. Two static configuration bits control the startup:
- A clock-source bit chooses between the internal RC oscillator and an external source.
- A delay bit chooses the short delay of `BASE_TICKS` ticks or the long delay of `BASE_TICKS*LONG_FACTOR` ticks. This is the 1 ms versus 16 ms choice.

The internal RC source always uses the short delay. All outputs are registered.

Top module: `sleep_ctl`

## Requirements
- R1: A cycle with `rst` high takes priority over all other inputs. At the next edge the outputs take the startup values: `osc_run`=1, `per_clk_en`=0, `cpu_clk_en`=0, `core_rdy`=0, and `osc_rc_en` equal to the inverse of `cfg_clk_ext`.
- R2: When `cfg_clk_ext`=1 and `cfg_long_dly`=0, the startup phase lasts exactly `BASE_TICKS` clock cycles with `ref_tick` high. At the edge that samples the last of these ticks, `core_rdy`, `cpu_clk_en` and `per_clk_en` all go to 1. The core state is then called run.
- R3: When `cfg_clk_ext`=1 and `cfg_long_dly`=1, the startup phase lasts exactly `BASE_TICKS*LONG_FACTOR` ticks.
- R4: When `cfg_clk_ext`=0 (internal RC source), the startup phase lasts `BASE_TICKS` ticks whatever `cfg_long_dly` is. In that case `osc_rc_en` follows `osc_run`. When `cfg_clk_ext`=1, `osc_rc_en` is 0.
- R5: In run, `sleep_req`=1 with `sleep_mode`=2'b01 (idle) gives, one cycle later, `cpu_clk_en`=0 while `per_clk_en`, `osc_run` and `core_rdy` stay 1.
- R6: In idle, `irq`=1 sets `cpu_clk_en` back to 1 at the next edge, with no startup delay. `ref_tick` has no effect in idle.
- R7: In run, `sleep_req`=1 with `sleep_mode`=2'b10 (power-down) gives, one cycle later, `osc_run`, `cpu_clk_en`, `per_clk_en`, `core_rdy` and `osc_rc_en` all at 0. `ref_tick` is ignored in power-down.
- R8: In power-down, `irq`=1 starts the startup phase at the next edge: `osc_run`=1 and `core_rdy`=0. The full selected delay, counted from zero, must then pass before run is reached.
- R9: A sleep request with `sleep_mode` 2'b00 or 2'b11 is ignored, and the core stays in run.
- R10: `sleep_req` is ignored outside run, that is during startup and during idle.
- R11: A reset during idle or power-down returns the block to the startup phase, even when `irq` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cfg_clk_ext | input | 1 | Clock-source bit: 0 = internal RC oscillator, 1 = external source |
| cfg_long_dly | input | 1 | Startup delay bit: 0 = short, 1 = long (external source only) |
| ref_tick | input | 1 | One-cycle reference tick used to count the startup delay |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_mode | input | 2 | Sleep depth: 01 idle, 10 power-down, others ignored |
| irq | input | 1 | Enabled interrupt pending (wake source) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral-domain clock enable (memory, timer, serial, interrupts) |
| osc_run | output | 1 | Oscillator run enable |
| osc_rc_en | output | 1 | Internal RC oscillator enable |
| core_rdy | output | 1 | Core released from startup |

## Verification
The bound checker tests on every cycle the rules that link the outputs to one another and to the inputs of the previous cycle:
- the CPU clock runs only when the core is ready;
- nothing is enabled while the oscillator is stopped;
- a reset forces the startup values;
- idle is entered and left in one cycle, and a wake from power-down lands in startup;
- undefined modes are ignored;
- the core becomes ready only on a tick.

Only the bench scenarios can show the exact length of the short, long and RC startup delays. The same holds for the delay counting restarting from zero after power-down, and for ticks and requests that arrive in the wrong state having no effect.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_RUN  = 2'd1,
    ST_IDLE = 2'd2,
    ST_HALT = 2'd3
  } pwr_state_t;

  localparam logic [1:0] MODE_IDLE = 2'b01;
  localparam logic [1:0] MODE_HALT = 2'b10;
endpackage

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int BASE_TICKS  = 8,
  parameter int LONG_FACTOR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  input  logic long_sel,
  output logic done
);
  localparam int LONG_TICKS = BASE_TICKS * LONG_FACTOR;
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(BASE_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = long_sel ? LONG_LAST : SHORT_LAST;
  assign done = active && tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic [1:0] sleep_mode,
  input  logic       irq,
  input  logic       boot_done,
  output pwr_state_t state_q,
  output pwr_state_t state_d
);
  always_comb begin
    state_d = state_q;
    if (rst) begin
      state_d = ST_BOOT;
    end else begin
      unique case (state_q)
        ST_BOOT: if (boot_done) state_d = ST_RUN;
        ST_RUN: begin
          if (sleep_req && sleep_mode == MODE_IDLE)      state_d = ST_IDLE;
          else if (sleep_req && sleep_mode == MODE_HALT) state_d = ST_HALT;
        end
        ST_IDLE: if (irq) state_d = ST_RUN;
        ST_HALT: if (irq) state_d = ST_BOOT;
        default: state_d = ST_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end
endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg
  import sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_t state_d,
  input  logic       clk_ext,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_run,
  output logic       osc_rc_en,
  output logic       core_rdy
);
  logic cpu_n, per_n, osc_n, rdy_n;

  always_comb begin
    cpu_n = 1'b0;
    per_n = 1'b0;
    osc_n = 1'b1;
    rdy_n = 1'b0;
    unique case (state_d)
      ST_BOOT: ;
      ST_RUN:  begin cpu_n = 1'b1; per_n = 1'b1; rdy_n = 1'b1; end
      ST_IDLE: begin per_n = 1'b1; rdy_n = 1'b1; end
      ST_HALT: osc_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b0;
      per_clk_en <= 1'b0;
      osc_run    <= 1'b1;
      core_rdy   <= 1'b0;
      osc_rc_en  <= !clk_ext;
    end else begin
      cpu_clk_en <= cpu_n;
      per_clk_en <= per_n;
      osc_run    <= osc_n;
      core_rdy   <= rdy_n;
      osc_rc_en  <= osc_n && !clk_ext;
    end
  end
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_pkg::*;
#(
  parameter int BASE_TICKS  = 8,
  parameter int LONG_FACTOR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_clk_ext,
  input  logic       cfg_long_dly,
  input  logic       ref_tick,
  input  logic       sleep_req,
  input  logic [1:0] sleep_mode,
  input  logic       irq,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_run,
  output logic       osc_rc_en,
  output logic       core_rdy
);
  pwr_state_t state_q, state_d;
  logic       boot_done;
  logic       long_eff;

  // The internal RC source always settles with the short delay.
  assign long_eff = cfg_long_dly && cfg_clk_ext;

  startup_timer #(
    .BASE_TICKS (BASE_TICKS),
    .LONG_FACTOR(LONG_FACTOR)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .active  (state_q == ST_BOOT),
    .tick    (ref_tick),
    .long_sel(long_eff),
    .done    (boot_done)
  );

  pwr_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .sleep_mode(sleep_mode),
    .irq       (irq),
    .boot_done (boot_done),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  pwr_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .clk_ext   (cfg_clk_ext),
    .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en),
    .osc_run   (osc_run),
    .osc_rc_en (osc_rc_en),
    .core_rdy  (core_rdy)
  );
endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_clk_ext,
  input logic       ref_tick,
  input logic       sleep_req,
  input logic [1:0] sleep_mode,
  input logic       irq,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_run,
  input logic       osc_rc_en,
  input logic       core_rdy
);
  p_rst_boot_r1: assert property (@(posedge clk)
    rst |=> (osc_run && !cpu_clk_en && !per_clk_en && !core_rdy));

  p_cpu_needs_rdy_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> core_rdy);

  p_rdy_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rdy) |-> $past(ref_tick));

  p_rc_follow_r4: assert property (@(posedge clk) disable iff (rst)
    osc_rc_en |-> (osc_run && !cfg_clk_ext));

  p_idle_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && sleep_mode == 2'b01) |=>
      (!cpu_clk_en && per_clk_en && core_rdy && osc_run));

  p_idle_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (core_rdy && !cpu_clk_en && irq) |=> cpu_clk_en);

  p_halt_off_r7: assert property (@(posedge clk) disable iff (rst)
    !osc_run |-> (!cpu_clk_en && !per_clk_en && !core_rdy && !osc_rc_en));

  p_halt_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (!osc_run && irq) |=> (osc_run && !core_rdy));

  p_undef_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && (sleep_mode == 2'b00 || sleep_mode == 2'b11))
      |=> cpu_clk_en);
endmodule

bind sleep_ctl sleep_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_clk_ext(cfg_clk_ext),
  .ref_tick   (ref_tick),
  .sleep_req  (sleep_req),
  .sleep_mode (sleep_mode),
  .irq        (irq),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_run    (osc_run),
  .osc_rc_en  (osc_rc_en),
  .core_rdy   (core_rdy)
);

// File: tb/sim_sleep_ctl.sv
`timescale 1ns/1ps
module sim_sleep_ctl;
  localparam int N = 8;
  localparam int F = 16;
  // Output vector {osc_run, per_clk_en, cpu_clk_en, core_rdy, osc_rc_en}.
  localparam logic [4:0] V_BOOT = 5'b10000;
  localparam logic [4:0] V_RUN  = 5'b11110;
  localparam logic [4:0] V_IDLE = 5'b11010;
  localparam logic [4:0] V_HALT = 5'b00000;
  localparam logic [4:0] V_BOOT_RC = 5'b10001;
  localparam logic [4:0] V_RUN_RC  = 5'b11111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_clk_ext = 1'b1, cfg_long_dly = 1'b0;
  logic ref_tick = 1'b0, sleep_req = 1'b0, irq = 1'b0;
  logic [1:0] sleep_mode = 2'b00;
  logic cpu_clk_en, per_clk_en, osc_run, osc_rc_en, core_rdy;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sleep_ctl #(.BASE_TICKS(N), .LONG_FACTOR(F)) u0 (
    .clk(clk), .rst(rst), .cfg_clk_ext(cfg_clk_ext), .cfg_long_dly(cfg_long_dly),
    .ref_tick(ref_tick), .sleep_req(sleep_req), .sleep_mode(sleep_mode), .irq(irq),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
    .osc_rc_en(osc_rc_en), .core_rdy(core_rdy)
  );

  function automatic logic [4:0] outs();
    return {osc_run, per_clk_en, cpu_clk_en, core_rdy, osc_rc_en};
  endfunction

  task automatic chk(input string tag, input logic [4:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs=%b expected=%b", tag, outs(), exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
    end
  endtask

  task automatic req(input logic [1:0] m);
    @(negedge clk) begin sleep_req = 1'b1; sleep_mode = m; end
    @(negedge clk) begin sleep_req = 1'b0; sleep_mode = 2'b00; end
  endtask

  task automatic wake();
    @(negedge clk) irq = 1'b1;
    @(negedge clk) irq = 1'b0;
  endtask

  task automatic t_short_boot();
    cfg_clk_ext = 1'b1; cfg_long_dly = 1'b0;
    do_reset();
    chk("R1 reset state", V_BOOT);
    ticks(N - 1);
    chk("R2 still held before last tick", V_BOOT);
    ticks(1);
    chk("R2 ready after BASE_TICKS ticks", V_RUN);
  endtask

  task automatic t_long_boot();
    cfg_clk_ext = 1'b1; cfg_long_dly = 1'b1;
    do_reset();
    ticks(N);
    chk("R3 short count not enough", V_BOOT);
    ticks(N * F - N - 1);
    chk("R3 held one tick before long delay", V_BOOT);
    ticks(1);
    chk("R3 ready after long delay", V_RUN);
  endtask

  task automatic t_rc_boot();
    cfg_clk_ext = 1'b0; cfg_long_dly = 1'b1;
    do_reset();
    chk("R4 rc enable during startup", V_BOOT_RC);
    ticks(N);
    chk("R4 rc source uses short delay", V_RUN_RC);
    req(2'b10);
    chk("R4 rc enable off in power-down", V_HALT);
    cfg_clk_ext = 1'b1; cfg_long_dly = 1'b0;
  endtask

  task automatic t_idle();
    do_reset(); ticks(N);
    req(2'b01);
    chk("R5 idle entry", V_IDLE);
    ticks(3);
    chk("R6 ticks ignored in idle", V_IDLE);
    req(2'b10);
    chk("R10 request ignored in idle", V_IDLE);
    wake();
    chk("R6 idle exit in one cycle", V_RUN);
    wake();
    chk("R6 interrupt in run has no effect", V_RUN);
  endtask

  task automatic t_undef();
    req(2'b00);
    chk("R9 mode 00 ignored", V_RUN);
    req(2'b11);
    chk("R9 mode 11 ignored", V_RUN);
  endtask

  task automatic t_halt();
    do_reset(); ticks(N);
    req(2'b10);
    chk("R7 power-down entry", V_HALT);
    ticks(N + 2);
    chk("R7 ticks ignored in power-down", V_HALT);
    wake();
    chk("R8 wake into startup", V_BOOT);
    ticks(N - 1);
    chk("R8 delay restarts from zero", V_BOOT);
    ticks(1);
    chk("R8 ready after full delay", V_RUN);
  endtask

  task automatic t_boot_req();
    do_reset();
    req(2'b01);
    chk("R10 request ignored during startup", V_BOOT);
    ticks(N);
    chk("R10 run reached normally", V_RUN);
  endtask

  task automatic t_reset_sleep();
    req(2'b10);
    @(negedge clk) begin rst = 1'b1; irq = 1'b1; end
    @(negedge clk) begin rst = 1'b0; irq = 1'b0; end
    chk("R11 reset beats irq in power-down", V_BOOT);
    ticks(N);
    req(2'b01);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R11 reset from idle", V_BOOT);
    ticks(N);
    chk("R11 run after reset from idle", V_RUN);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: outputs=%b expected=finished", outs());
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_short_boot();
    t_long_boot();
    t_rc_boot();
    t_idle();
    t_undef();
    t_halt();
    t_boot_req();
    t_reset_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule